// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block translates a 32-bit virtual address into a 32-bit physical address by walking a two-level page table in memory, with 4 KiB pages and 4 MiB superpages. A request brings the virtual address, the kind of access (fetch, load or store) and the privilege of the requester. The block works out the effective privilege, reads page table entries over a simple request/acknowledge memory port, and checks privilege and access rights. It sets the accessed and dirty bits by writing the entry back when they change. It returns either a physical address with read, write and execute rights, or a page fault carrying a cause code and the faulting address.

Only one walk is in flight at a time. While `busy` is high, new requests are ignored. The control inputs (paging enable, root page number, modify-privilege, previous privilege, SUM, MXR) are expected to stay stable while a walk runs. The memory port holds `mem_req` and `mem_addr` until `mem_ack`. On a read, the entry is taken from `mem_rdata` in the acknowledge cycle.

Encodings: access kind 0 = fetch, 1 = load, 2 = store. Privilege 0 = user, 1 = supervisor, 3 = machine. Entry bits: V=0, R=1, W=2, X=3, U=4, A=6, D=7. The page number is bits 29:10.

Top module: `page_walker`

## Requirements
- R1: When paging is off, or the effective privilege is machine (3), the result comes without any memory access: physical address equal to the virtual address, and read, write and execute all granted.
- R2: For loads and stores (kind 1 or 2) at machine privilege with `mod_priv` set, the effective privilege is `prev_priv`. Fetches (kind 0) keep machine privilege whatever `mod_priv` is.
- R3: The first entry is read at `{root_ppn,12'h000} + 4*va[31:22]`. An entry with V=1 and R=W=X=0 is a pointer. The second entry is read at `{pte[29:10],12'h000} + 4*va[21:12]`.
- R4: A leaf with U=1 faults at supervisor privilege unless `sum` is 1. A leaf with U=0 faults at user privilege.
- R5: An entry with V=0, or with W=1 and R=0, faults.
- R6: A fetch needs X=1. A load needs R=1, or X=1 with `mxr` set. A store needs both R=1 and W=1. Otherwise the access faults.
- R7: On a permitted leaf, the entry ORed with A (bit 6), and also with D (bit 7) for stores, is written back to the same address only if it differs from the entry read.
- R8: A leaf found at the first level maps a superpage: the physical address is `{pte[29:20], va[21:0]}`. A leaf at the second level gives `{pte[29:10], va[11:0]}`.
- R9: `res_r` = R and `res_x` = X of the leaf. `res_w` is 1 only when W=1 and the access is a store or D=1 already.
- R10: A pointer entry found at the second level faults.
- R11: A fault reports `res_cause` 12 for fetch, 13 for load and 15 for store. It also gives `res_tval` = the virtual address, `res_paddr` = 0 and no rights.
- R12: After reset the block is idle with no result and no memory request. `res_valid` pulses once per accepted request. A request made while `busy` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start a translation (taken when not busy) |
| req_vaddr | input | 32 | Virtual address |
| req_kind | input | 2 | 0 fetch, 1 load, 2 store |
| req_priv | input | 2 | Requester privilege: 0 user, 1 supervisor, 3 machine |
| paging_on | input | 1 | 1 enables two-level translation, 0 is bare |
| root_ppn | input | 20 | Page number of the first-level table |
| mod_priv | input | 1 | Data accesses at machine privilege use `prev_priv` |
| prev_priv | input | 2 | Saved previous privilege |
| sum | input | 1 | Supervisor may touch user pages |
| mxr | input | 1 | Executable pages are readable by loads |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Pending access is a write-back |
| mem_addr | output | 32 | Entry address |
| mem_wdata | output | 32 | Entry value to write |
| mem_ack | input | 1 | Access completes this cycle |
| mem_rdata | input | 32 | Entry read, valid with `mem_ack` |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Page fault |
| res_cause | output | 4 | Fault cause code |
| res_paddr | output | 32 | Physical address |
| res_tval | output | 32 | Virtual address of the request |
| res_r | output | 1 | Read allowed |
| res_w | output | 1 | Write allowed |
| res_x | output | 1 | Execute allowed |

## Verification
A bare or machine-privilege result is due in the cycle right after the request is accepted. A walked result is due in the cycle after the acknowledge of the last memory access, whether that access is the second read or the write-back. The bench predicts the number of accesses from its own model of the table. Once per clock it checks that `res_valid` stays low until that final acknowledge and is high exactly one cycle after it. It also checks every access address and write-back value at the cycle its acknowledge is given, and then checks that no further result or request follows.

// File: rtl/page_walker.sv
module page_walker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_vaddr,
  input  logic [1:0]  req_kind,
  input  logic [1:0]  req_priv,
  input  logic        paging_on,
  input  logic [19:0] root_ppn,
  input  logic        mod_priv,
  input  logic [1:0]  prev_priv,
  input  logic        sum,
  input  logic        mxr,
  output logic        busy,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        res_valid,
  output logic        res_fault,
  output logic [3:0]  res_cause,
  output logic [31:0] res_paddr,
  output logic [31:0] res_tval,
  output logic        res_r,
  output logic        res_w,
  output logic        res_x
);
  typedef enum logic [1:0] {IDLE, READ, WBACK} st_t;

  st_t         st;
  logic        top;
  logic [31:0] base, va, wb;
  logic [1:0]  kind, prv;
  logic        sum_q, mxr_q;

  wire [1:0]  eff    = (req_priv == 2'd3 && req_kind != 2'd0 && mod_priv) ? prev_priv : req_priv;
  wire [9:0]  idx    = top ? va[31:22] : va[21:12];
  wire [31:0] d      = mem_rdata;
  wire        is_fe  = (kind == 2'd0);
  wire        is_st  = kind[1];
  wire        is_ptr = d[0] & ~|d[3:1];
  wire        u_bad  = d[4] ? (prv == 2'd1 && !sum_q) : (prv != 2'd1);
  wire        e_bad  = ~d[0] | (d[2] & ~d[1]);
  wire        p_bad  = is_fe ? ~d[3] : (is_st ? ~(d[1] & d[2]) : ~(d[1] | (mxr_q & d[3])));
  wire [31:0] upd    = d | 32'h40 | (is_st ? 32'h80 : 32'h0);
  wire [19:0] ppn    = top ? {d[29:20], va[21:12]} : d[29:10];
  wire [3:0]  cause  = is_fe ? 4'd12 : (is_st ? 4'd15 : 4'd13);
  wire        fault  = is_ptr ? !top : (u_bad | e_bad | p_bad);

  assign busy      = (st != IDLE);
  assign mem_req   = busy;
  assign mem_we    = (st == WBACK);
  assign mem_addr  = base + {20'd0, idx, 2'b00};
  assign mem_wdata = wb;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= IDLE; top <= 1'b1; base <= '0; va <= '0; wb <= '0;
      kind <= '0; prv <= '0; sum_q <= 1'b0; mxr_q <= 1'b0;
      res_valid <= 1'b0; res_fault <= 1'b0; res_cause <= '0;
      res_paddr <= '0; res_tval <= '0; res_r <= 1'b0; res_w <= 1'b0; res_x <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        IDLE: if (req_valid) begin
          va <= req_vaddr; kind <= req_kind; prv <= eff;
          sum_q <= sum; mxr_q <= mxr; top <= 1'b1;
          base <= {root_ppn, 12'h000};
          res_tval <= req_vaddr;
          if (!paging_on || eff == 2'd3) begin
            res_valid <= 1'b1; res_fault <= 1'b0; res_cause <= '0;
            res_paddr <= req_vaddr;
            res_r <= 1'b1; res_w <= 1'b1; res_x <= 1'b1;
          end else begin
            st <= READ;
          end
        end
        READ: if (mem_ack) begin
          if (fault) begin
            res_valid <= 1'b1; res_fault <= 1'b1; res_cause <= cause;
            res_paddr <= '0; res_r <= 1'b0; res_w <= 1'b0; res_x <= 1'b0;
            st <= IDLE;
          end else if (is_ptr) begin
            base <= {d[29:10], 12'h000};
            top  <= 1'b0;
          end else begin
            res_fault <= 1'b0; res_cause <= '0;
            res_paddr <= {ppn, va[11:0]};
            res_r <= d[1]; res_x <= d[3]; res_w <= d[2] & (is_st | d[7]);
            if (upd != d) begin
              wb <= upd;
              st <= WBACK;
            end else begin
              res_valid <= 1'b1;
              st <= IDLE;
            end
          end
        end
        WBACK: if (mem_ack) begin
          res_valid <= 1'b1;
          st <= IDLE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  p_hold_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));
  p_wb_sets_a_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_wdata[6] && mem_wdata[0]);
  p_fault_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_fault |-> (res_cause == 4'd12 || res_cause == 4'd13 || res_cause == 4'd15)
                               && !res_r && !res_w && !res_x);
  p_write_implies_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_w |-> !res_fault && res_r);
  p_result_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !busy);
endmodule

// File: tb/sim_page_walker.sv
module sim_page_walker;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [31:0] req_vaddr = '0;
  logic [1:0] req_kind = '0, req_priv = '0;
  logic paging_on = 1'b0, mod_priv = 1'b0, sum = 1'b0, mxr = 1'b0;
  logic [19:0] root_ppn = 20'd1;
  logic [1:0] prev_priv = '0;
  logic busy, mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic res_valid, res_fault, res_r, res_w, res_x;
  logic [3:0] res_cause;
  logic [31:0] res_paddr, res_tval;

  page_walker u0 (.*);

  always #2 clk = ~clk;

  localparam int LAT = 1;
  localparam logic [31:0] FV = 32'h01, FR = 32'h02, FW = 32'h04, FX = 32'h08,
                          FU = 32'h10, FA = 32'h40, FD = 32'h80;
  localparam logic [31:0] VA_A = 32'h0040_3123, VA_S = 32'h0080_5678,
                          VA_P = 32'h0040_4000, VA_N = 32'h00C0_0000;

  logic [31:0] mem [0:4095];
  int total = 0, failed = 0;

  logic e_fault, e_r, e_w, e_x, e_wb;
  logic [3:0] e_cause;
  logic [31:0] e_paddr, e_wbaddr, e_wbval;
  logic [31:0] e_raddr [0:1];
  int e_nacc;

  function automatic logic [31:0] mk(input logic [19:0] ppn, input logic [31:0] fl);
    return {2'b00, ppn, 10'd0} | fl;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic set_fault(input logic [1:0] k);
    e_fault = 1'b1; e_cause = (k == 0) ? 4'd12 : (k == 1) ? 4'd13 : 4'd15;
    e_paddr = '0; e_r = 1'b0; e_w = 1'b0; e_x = 1'b0;
  endtask

  task automatic predict(input logic [31:0] va, input logic [1:0] k, input logic [1:0] pv);
    logic [1:0] ep;
    logic [31:0] b, a, p, np;
    bit allow, perm;
    ep = (pv == 2'd3 && k != 2'd0 && mod_priv) ? prev_priv : pv;
    e_fault = 1'b0; e_cause = '0; e_nacc = 0; e_wb = 1'b0;
    e_r = 1'b1; e_w = 1'b1; e_x = 1'b1; e_paddr = va;
    if (ep == 2'd3 || !paging_on) return;
    b = {root_ppn, 12'h000};
    for (int lv = 1; lv >= 0; lv--) begin
      a = b + 32'((lv == 1 ? va[31:22] : va[21:12])) * 4;
      p = mem[a[13:2]];
      e_raddr[e_nacc] = a;
      e_nacc++;
      if (p[0] && p[3:1] == 3'b000) begin
        if (lv == 0) begin set_fault(k); return; end
        b = {p[29:10], 12'h000};
        continue;
      end
      allow = p[4] ? (ep == 2'd0 || sum) : (ep == 2'd1);
      if (k == 2'd0) perm = p[3];
      else if (k == 2'd1) perm = p[1] || (mxr && p[3]);
      else perm = p[1] && p[2];
      if (!allow || !p[0] || (p[2] && !p[1]) || !perm) begin set_fault(k); return; end
      np = p | FA | ((k >= 2) ? FD : 32'h0);
      if (np != p) begin e_wb = 1'b1; e_wbaddr = a; e_wbval = np; e_nacc++; end
      e_paddr = (lv == 1) ? {p[29:20], va[21:0]} : {p[29:10], va[11:0]};
      e_r = p[1]; e_x = p[3]; e_w = p[2] && (k >= 2 || p[7]);
      return;
    end
  endtask

  task automatic setc(input bit en, input bit mp, input logic [1:0] pp, input bit s, input bit m);
    paging_on = en; mod_priv = mp; prev_priv = pp; sum = s; mxr = m;
  endtask

  task automatic run(input string tag, input logic [31:0] va, input logic [1:0] k,
                     input logic [1:0] pv, input bit poke);
    int acks, nrd, cnt;
    bit got, lastack;
    predict(va, k, pv);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_kind = k; req_priv = pv;
    @(negedge clk);
    req_valid = 1'b0;
    acks = 0; nrd = 0; cnt = 0; got = 0; lastack = 0;
    for (int i = 0; i < 300 && !got; i++) begin
      if (res_valid) begin
        got = 1;
        chk(acks == e_nacc, tag, "result before last access", acks, e_nacc);
        chk(res_fault == e_fault, tag, "fault", res_fault, e_fault);
        if (e_fault) begin
          chk(res_cause == e_cause, tag, "cause R11", res_cause, e_cause);
          chk(res_tval == va, tag, "tval R11", res_tval, va);
        end
        chk(res_paddr == e_paddr, tag, "paddr", res_paddr, e_paddr);
        chk({res_r, res_w, res_x} == {e_r, e_w, e_x}, tag, "rwx",
            {29'd0, res_r, res_w, res_x}, {29'd0, e_r, e_w, e_x});
      end else if (lastack) begin
        chk(1'b0, tag, "result missing after last access", 0, 1);
      end
      lastack = 0;
      mem_ack = 1'b0;
      req_valid = poke && (i == 1);
      if (poke && i == 1) begin req_vaddr = 32'h0; req_priv = 2'd3; end
      if (!got && mem_req) begin
        if (cnt == LAT) begin
          mem_ack = 1'b1; cnt = 0; acks++;
          if (mem_we) begin
            chk(e_wb && mem_addr == e_wbaddr, tag, "R7 writeback addr", mem_addr, e_wbaddr);
            chk(mem_wdata == e_wbval, tag, "R7 writeback data", mem_wdata, e_wbval);
            mem[mem_addr[13:2]] = mem_wdata;
          end else begin
            chk(nrd < 2 && mem_addr == e_raddr[nrd < 2 ? nrd : 0], tag, "R3 read addr",
                mem_addr, e_raddr[nrd < 2 ? nrd : 0]);
            mem_rdata = mem[mem_addr[13:2]];
            nrd++;
          end
          if (acks == e_nacc) lastack = 1;
        end else begin
          cnt++;
        end
      end
      @(negedge clk);
    end
    mem_ack = 1'b0; req_valid = 1'b0;
    if (!got) chk(1'b0, tag, "timeout", 0, 1);
    if (e_wb) chk(mem[e_wbaddr[13:2]] == e_wbval, tag, "R7 entry in memory",
                  mem[e_wbaddr[13:2]], e_wbval);
    for (int j = 0; j < 3; j++) begin
      if (poke) chk(!res_valid && !mem_req, tag, "R12 busy request ignored",
                    {30'd0, res_valid, mem_req}, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    #(4 * 150000);
    failed++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    mem[12'h401] = mk(20'd2, FV);
    mem[12'h804] = mk(20'd2, FV);
    mem[12'h402] = mk(20'h2A500, FV | FR | FW | FX | FA | FD);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !res_valid && !mem_req, "R12", "reset state",
        {29'd0, busy, res_valid, mem_req}, 0);

    setc(0, 0, 0, 0, 0);
    run("R1 bare", 32'hDEAD_BEEF, 2'd1, 2'd1, 0);
    setc(1, 1, 1, 0, 0);
    run("R1 R2 machine fetch", VA_A, 2'd0, 2'd3, 0);
    mem[12'h803] = mk(20'h12345, FV | FR | FW | FA | FD);
    run("R2 R3 modified privilege load", VA_A, 2'd1, 2'd3, 0);
    setc(1, 0, 0, 0, 0);
    run("R4 user on kernel page", VA_A, 2'd1, 2'd0, 0);
    mem[12'h803] = mk(20'h12345, FV | FR | FU | FA);
    run("R4 supervisor on user page", VA_A, 2'd1, 2'd1, 0);
    setc(1, 0, 0, 1, 0);
    run("R4 supervisor on user page with sum", VA_A, 2'd1, 2'd1, 0);
    setc(1, 0, 0, 0, 0);
    mem[12'h803] = mk(20'h12345, FR | FU | FA);
    run("R5 invalid leaf", VA_A, 2'd1, 2'd0, 0);
    mem[12'h803] = mk(20'h12345, FV | FW | FU | FA);
    run("R5 R11 write without read", VA_A, 2'd2, 2'd0, 0);
    mem[12'h803] = mk(20'h12345, FV | FR | FU | FA);
    run("R6 R11 fetch without X", VA_A, 2'd0, 2'd0, 0);
    mem[12'h803] = mk(20'h12345, FV | FX | FU | FA);
    run("R6 load X-only", VA_A, 2'd1, 2'd0, 0);
    setc(1, 0, 0, 0, 1);
    run("R6 load X-only with mxr", VA_A, 2'd1, 2'd0, 0);
    run("R6 fetch X-only", VA_A, 2'd0, 2'd0, 0);
    setc(1, 0, 0, 0, 0);
    mem[12'h803] = mk(20'h12345, FV | FR | FU | FA | FD);
    run("R6 R11 store on read-only", VA_A, 2'd2, 2'd0, 0);
    mem[12'h803] = mk(20'h12345, FV | FR | FW | FU);
    run("R7 R9 store sets A and D", VA_A, 2'd2, 2'd0, 0);
    mem[12'h803] = mk(20'h12345, FV | FR | FW | FU | FA);
    run("R7 R9 clean load no writeback", VA_A, 2'd1, 2'd0, 0);
    mem[12'h803] = mk(20'h12345, FV | FR | FW | FU | FA | FD);
    run("R9 dirty load gets write", VA_A, 2'd1, 2'd0, 0);
    mem[12'h803] = mk(20'h12345, FV | FR | FU);
    run("R7 load sets A", VA_A, 2'd1, 2'd0, 0);
    run("R8 superpage", VA_S, 2'd1, 2'd1, 0);
    run("R8 superpage fetch", VA_S + 32'h0003_F000, 2'd0, 2'd1, 0);
    run("R10 pointer at last level", VA_P, 2'd1, 2'd0, 0);
    run("R5 invalid root entry", VA_N, 2'd2, 2'd1, 0);
    mem[12'h803] = mk(20'h12345, FV | FR | FU | FA | FD);
    run("R12 request while busy", VA_A, 2'd1, 2'd0, 1);

    $display("[TB] %0d tests run, %0d failed", total, failed);
    $finish;
  end
endmodule